// File: doc/BRIEF.md
# Nested Trunk/Local Clock Gating Controller

This block decides when the clocks of an imaging unit may stop. It has two cooperating state machines. The outer machine controls the shared trunk clock enable. The inner machine controls the clock enable that is local to the unit. The local clock is stopped only after the unit's pending write FIFO reports empty. The trunk clock is stopped only after the local clock has stopped. A wake request restarts the trunk clock first. The local clock is then released, and the outer machine returns to run once the local clock is running again.

After reset both machines sit in their run states. Unless a keep-running strap is tied high, a boot timer fires a configurable number of cycles after reset is released. The timer launches one automatic gating pass. During normal operation, a gating-enable input starts a gating pass whenever the unit reports idle. A read-only status byte reports both state codes and the busy input. The block only produces enable signals; the clock cells that use them are outside it.

Top module: `cgn_top`

## Requirements
- R1: While reset is low and on the first cycle after it, both state codes are 0, both clock enables are 1 and status bits 7:1 are 0.
- R2: The trunk state code is 3 bits and appears in status bits 6:4. The codes are: 0 = trunk running, 1 = trunk stopped, 2 = waiting for resume, 3 = trunk restarting, 4 = waiting for the local clock.
- R3: The local state code is 2 bits and appears in status bits 2:1. The codes are: 0 = local running, 1 = draining the FIFO, 2 = local stopped.
- R4: Status bit 0 follows the busy input (1 = busy, 0 = idle), and status bits 7 and 3 always read 0.
- R5: When the strap is low, the boot timer expires on the BOOT_DELAY-th rising edge with reset high. One edge later the local code becomes 1, provided busy is low. On the next edge it becomes 2, provided the FIFO is empty. On the edge after that the trunk code becomes 1.
- R6: When the strap is high, no automatic gating happens: with gating-enable low, both codes stay 0 indefinitely.
- R7: The local machine leaves code 0 only on an edge where busy is low and either gating-enable is high or the automatic pass is still pending.
- R8: The local machine reaches code 2 only from code 1, and only on an edge where the FIFO-empty flag is high. Otherwise it stays at 1.
- R9: The trunk machine moves from 0 to 1 on the edge after the local code has become 2.
- R10: In trunk code 1, a wake request moves the trunk to code 2. It then moves to 3 and to 4 on the next two edges. In trunk code 4 the local machine returns to 0 on the next edge, and the trunk returns to 0 on the edge after that.
- R11: The trunk clock enable is 1 exactly in trunk codes 0, 3 and 4. The local clock enable is 1 exactly in local codes 0 and 1.
- R12: The automatic pass happens only once per reset: after a wake returns both machines to run, they stay at 0 while gating-enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gate_en | input | 1 | Request to gate when the unit is idle |
| wake_req | input | 1 | Resume request while the trunk is stopped |
| fifo_empty | input | 1 | Pending write FIFO is empty |
| unit_busy | input | 1 | Unit busy indication |
| keep_run_strap | input | 1 | High suppresses the automatic gating pass after reset |
| trunk_clk_en | output | 1 | Enable for the trunk clock gate |
| local_clk_en | output | 1 | Enable for the local clock gate |
| status_o | output | 8 | {0, trunk code[2:0], 0, local code[1:0], busy} |

## Verification
Two functions can fall in the same cycle: the boot timer's automatic gating request, and the unit's busy indication that blocks the local machine from leaving run. The bench provokes the overlap by holding busy high from reset until well past the timer's expiry. It then checks that the local code stays 0 and that status bit 0 reads 1. When busy is dropped, the bench checks that the pending automatic request carries the local machine to code 1 on exactly the next edge. A separate walk of a stimulus table overlaps the release of the local machine with the trunk machine's wait for it, and checks each state code edge by edge.

// File: rtl/cgn_pkg.sv
package cgn_pkg;
   localparam int TRUNK_W = 3;
   localparam int LOCAL_W = 2;

   typedef enum logic [TRUNK_W-1:0] {
      TK_RUN   = 3'd0,
      TK_STOP  = 3'd1,
      TK_WRES  = 3'd2,
      TK_START = 3'd3,
      TK_WLOC  = 3'd4
   } trunk_st_e;

   typedef enum logic [LOCAL_W-1:0] {
      LC_RUN   = 2'd0,
      LC_DRAIN = 2'd1,
      LC_STOP  = 2'd2
   } local_st_e;
endpackage

// File: rtl/cgn_boot_timer.sv
module cgn_boot_timer #(
   parameter int unsigned BOOT_DELAY = 16
) (
   input  logic clk,
   input  logic rst_n,
   output logic done_o
);
   localparam int CNT_W = (BOOT_DELAY < 2) ? 1 : $clog2(BOOT_DELAY + 1);

   generate
      if (BOOT_DELAY > 65535) begin : g_bad_delay
         $error("cgn_boot_timer: BOOT_DELAY too large");
      end

      if (BOOT_DELAY == 0) begin : g_immediate
         assign done_o = 1'b1;
      end else begin : g_count
         logic [CNT_W-1:0] cnt_q;
         logic             done_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q  <= '0;
               done_q <= 1'b0;
            end else if (!done_q) begin
               cnt_q  <= cnt_q + 1'b1;
               done_q <= (cnt_q == CNT_W'(BOOT_DELAY - 1));
            end
         end

         assign done_o = done_q;

         assert_done_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
            done_q |=> done_q);
      end
   endgenerate
endmodule

// File: rtl/cgn_local_fsm.sv
module cgn_local_fsm
   import cgn_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      go_i,
   input  logic      fifo_empty_i,
   input  logic      release_i,
   output local_st_e state_o,
   output logic      clk_en_o
);
   local_st_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         LC_RUN:   if (go_i)         st_d = LC_DRAIN;
         LC_DRAIN: if (fifo_empty_i) st_d = LC_STOP;
         LC_STOP:  if (release_i)    st_d = LC_RUN;
         default:                    st_d = LC_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= LC_RUN;
      else        st_q <= st_d;
   end

   assign state_o  = st_q;
   assign clk_en_o = (st_q == LC_RUN) || (st_q == LC_DRAIN);

   assert_stop_via_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == LC_DRAIN && !fifo_empty_i) |=> (st_q == LC_DRAIN));

   assert_run_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == LC_RUN && !go_i) |=> (st_q == LC_RUN));
endmodule

// File: rtl/cgn_trunk_fsm.sv
module cgn_trunk_fsm
   import cgn_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  local_st_e local_st_i,
   input  logic      wake_i,
   output trunk_st_e state_o,
   output logic      release_o,
   output logic      clk_en_o
);
   trunk_st_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         TK_RUN:   if (local_st_i == LC_STOP) st_d = TK_STOP;
         TK_STOP:  if (wake_i)                st_d = TK_WRES;
         TK_WRES:                             st_d = TK_START;
         TK_START:                            st_d = TK_WLOC;
         TK_WLOC:  if (local_st_i == LC_RUN)  st_d = TK_RUN;
         default:                             st_d = TK_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= TK_RUN;
      else        st_q <= st_d;
   end

   assign state_o   = st_q;
   assign release_o = (st_q == TK_WLOC);
   assign clk_en_o  = (st_q == TK_RUN) || (st_q == TK_START) || (st_q == TK_WLOC);

   assert_trunk_stop_after_local_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == TK_RUN && local_st_i != LC_STOP) |=> (st_q == TK_RUN));

   assert_resume_order_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == TK_WRES) |=> (st_q == TK_START));
endmodule

// File: rtl/cgn_top.sv
module cgn_top
   import cgn_pkg::*;
#(
   parameter int unsigned BOOT_DELAY = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       gate_en,
   input  logic       wake_req,
   input  logic       fifo_empty,
   input  logic       unit_busy,
   input  logic       keep_run_strap,
   output logic       trunk_clk_en,
   output logic       local_clk_en,
   output logic [7:0] status_o
);
   logic      boot_done;
   logic      auto_spent_q;
   logic      auto_pending;
   logic      local_go;
   logic      release_w;
   local_st_e local_st;
   trunk_st_e trunk_st;

   cgn_boot_timer #(.BOOT_DELAY(BOOT_DELAY)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .done_o (boot_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  auto_spent_q <= 1'b0;
      else if (local_st == LC_STOP) auto_spent_q <= 1'b1;
   end

   assign auto_pending = boot_done && !keep_run_strap && !auto_spent_q;
   assign local_go     = (gate_en || auto_pending) && !unit_busy;

   cgn_local_fsm u_local (
      .clk          (clk),
      .rst_n        (rst_n),
      .go_i         (local_go),
      .fifo_empty_i (fifo_empty),
      .release_i    (release_w),
      .state_o      (local_st),
      .clk_en_o     (local_clk_en)
   );

   cgn_trunk_fsm u_trunk (
      .clk        (clk),
      .rst_n      (rst_n),
      .local_st_i (local_st),
      .wake_i     (wake_req),
      .state_o    (trunk_st),
      .release_o  (release_w),
      .clk_en_o   (trunk_clk_en)
   );

   assign status_o = {1'b0, trunk_st, 1'b0, local_st, unit_busy};

   assert_local_stopped_gates_trunk_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (local_st == LC_STOP && trunk_st == TK_STOP) |-> (!trunk_clk_en && !local_clk_en));

   assert_auto_once_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_spent_q && keep_run_strap == 1'b0 && !gate_en && local_st == LC_RUN)
         |=> (local_st == LC_RUN));
endmodule

// File: tb/cgn_top_tb_top.sv
module cgn_top_tb_top;
   localparam int DLY = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic gate_en = 1'b0, wake_req = 1'b0, fifo_empty = 1'b0, unit_busy = 1'b0, keep_run_strap = 1'b0;
   logic trunk_clk_en, local_clk_en;
   logic [7:0] status_o;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   cgn_top #(.BOOT_DELAY(DLY)) dut_i (
      .clk(clk), .rst_n(rst_n), .gate_en(gate_en), .wake_req(wake_req),
      .fifo_empty(fifo_empty), .unit_busy(unit_busy), .keep_run_strap(keep_run_strap),
      .trunk_clk_en(trunk_clk_en), .local_clk_en(local_clk_en), .status_o(status_o)
   );

   // row: {gate, wake, fifo_empty, busy, trunk[2:0], local[1:0]}
   localparam int NROW = 13;
   localparam logic [8:0] VEC [NROW] = '{
      9'b0000_000_00, 9'b1001_000_00, 9'b1000_000_01, 9'b1000_000_01,
      9'b1010_000_10, 9'b0010_001_10, 9'b0000_001_10, 9'b0100_010_10,
      9'b0000_011_10, 9'b0000_100_10, 9'b0000_100_00, 9'b0000_000_00,
      9'b0001_000_00
   };

   function automatic logic [7:0] exp_stat(logic [2:0] t, logic [1:0] l, logic b);
      return {1'b0, t, 1'b0, l, b};
   endfunction

   task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic chk_all(string req, logic [2:0] t, logic [1:0] l);
      chk(req, status_o, exp_stat(t, l, unit_busy));
      chk({req, " R11 tce"}, {7'd0, trunk_clk_en}, {7'd0, (t == 3'd0 || t == 3'd3 || t == 3'd4)});
      chk({req, " R11 lce"}, {7'd0, local_clk_en}, {7'd0, (l == 2'd0 || l == 2'd1)});
   endtask

   task automatic do_reset(logic strap, logic busy);
      @(negedge clk);
      rst_n = 1'b0; gate_en = 1'b0; wake_req = 1'b0; fifo_empty = 1'b1;
      unit_busy = busy; keep_run_strap = strap;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic edge_sample;
      @(posedge clk); #1;
   endtask

   initial begin
      #(4 * 100000);
      if (!finished) begin
         bad++; total++;
         $display("FAIL watchdog R1 act=hung exp=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // R1 reset state
      do_reset(1'b0, 1'b0);
      rst_n = 1'b0;
      @(negedge clk);
      chk_all("R1 in reset", 3'd0, 2'd0);
      rst_n = 1'b1;
      edge_sample;
      chk_all("R1 after release", 3'd0, 2'd0);

      // Table walk with strap high (R2 R3 R4 R7 R8 R9 R10 R11)
      do_reset(1'b1, 1'b0);
      for (int i = 0; i < NROW; i++) begin
         {gate_en, wake_req, fifo_empty, unit_busy} = VEC[i][8:5];
         edge_sample;
         chk_all($sformatf("table row %0d R2 R3 R4 R7 R8 R9 R10", i), VEC[i][4:2], VEC[i][1:0]);
         @(negedge clk);
      end
      chk("R4 reserved bits", {6'd0, status_o[7], status_o[3]}, 8'd0);

      // R6 strap high: no automatic pass
      do_reset(1'b1, 1'b0);
      repeat (DLY + 8) @(negedge clk);
      chk_all("R6 strap holds run", 3'd0, 2'd0);

      // R5 automatic pass timing
      do_reset(1'b0, 1'b0);
      for (int k = 1; k <= DLY + 3; k++) begin
         edge_sample;
         if (k <= DLY)          chk_all("R5 before expiry", 3'd0, 2'd0);
         else if (k == DLY + 1) chk_all("R5 drain", 3'd0, 2'd1);
         else if (k == DLY + 2) chk_all("R5 local stop", 3'd0, 2'd2);
         else                   chk_all("R5 R9 trunk stop", 3'd1, 2'd2);
      end
      // wake, then R12 no second automatic pass
      @(negedge clk); wake_req = 1'b1;
      @(negedge clk); wake_req = 1'b0;
      repeat (5) @(negedge clk);
      chk_all("R10 back to run", 3'd0, 2'd0);
      repeat (30) @(negedge clk);
      chk_all("R12 single auto pass", 3'd0, 2'd0);

      // Overlap: automatic request while busy (R7)
      do_reset(1'b0, 1'b1);
      repeat (DLY + 6) @(negedge clk);
      chk_all("R7 R4 busy blocks auto", 3'd0, 2'd0);
      unit_busy = 1'b0;
      edge_sample;
      chk_all("R7 auto after idle", 3'd0, 2'd1);
      @(negedge clk); fifo_empty = 1'b0;
      repeat (3) @(negedge clk);
      chk_all("R8 wait for fifo", 3'd0, 2'd1);
      fifo_empty = 1'b1;
      edge_sample;
      chk_all("R8 stop on empty", 3'd0, 2'd2);

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule